// File: doc/BRIEF.md
# BIOS Region Address Decoder

This block inspects each memory access and decides whether it falls in firmware (BIOS) space. For each such access it chooses one of three outcomes. The access can be claimed and passed to the expansion bus, it can be sent to main memory, or it can be ignored. It also decides whether the firmware chip select is driven. The rules differ by initiator. A host-side master can reach the legacy 128 KB window, its alias at the top of the 4 GB space, and an extended 384 KB area. An expansion-bus master can reach only the legacy window.

A small control register sets the policy. It holds an enable for the lower 64 KB legacy half, which also gates that half's top-of-memory alias. It holds an enable for the extended area, and one write-protect bit that covers all firmware space. Each decision is registered. It appears one clock after the request strobe, together with a one-cycle valid pulse.

Top module: `bios_region_decoder`

## Requirements
- R1: After reset the control register holds zero (both optional regions disabled, protection off) and all outputs are low.
- R2: A request sampled on a clock edge produces `dec_valid_o` high for exactly one cycle after that edge, carrying that request's decision. With no request, every decision output is low in the following cycle.
- R3: A host access to 0x000F0000–0x000FFFFF or 0xFFFF0000–0xFFFFFFFF is always claimed with chip select.
- R4: A host access to 0x000E0000–0x000EFFFF is always claimed. Chip select is driven only when control bit 6 (lower enable) is 1.
- R5: A host access to 0xFFFE0000–0xFFFEFFFF is claimed with chip select only when control bit 6 is 1. Otherwise it produces no claim and no chip select.
- R6: A host access to 0xFFF80000–0xFFFDFFFF is claimed with chip select only when control bit 7 (extended enable) is 1. Otherwise it produces nothing.
- R7: An expansion-bus access to 0x000F0000–0x000FFFFF is claimed with chip select and is never sent to memory.
- R8: An expansion-bus access to 0x000E0000–0x000EFFFF is claimed with chip select when bit 6 is 1. When bit 6 is 0 it raises `to_mem_o` with no claim and no chip select. An expansion-bus access to any other address, including the high ranges, produces nothing.
- R9: When control bit 0 (write protect) is 1, a write that would be claimed is still claimed. Its chip select is suppressed and `wp_err_o` pulses for that one cycle. Reads are unaffected.
- R10: An access outside every firmware range produces no claim, no memory forward and no chip select.
- R11: A control write (`cfg_we_i`) takes effect for requests from the next cycle on. A request in the same cycle as the write is decoded with the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request strobe |
| addr_i | input | 32 | Access byte address |
| wr_i | input | 1 | 1 = write, 0 = read |
| from_exp_i | input | 1 | 1 = expansion-bus master, 0 = host-side master |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | 8 | Control register write data (bit 0 protect, bit 6 lower enable, bit 7 extended enable) |
| dec_valid_o | output | 1 | One-cycle pulse marking a decision |
| claim_o | output | 1 | Access claimed, passed to expansion bus |
| to_mem_o | output | 1 | Access sent to main memory |
| bios_cs_o | output | 1 | Firmware chip select |
| wp_err_o | output | 1 | Write-protect violation pulse |

## Verification
The assertions take `req_i` and `cfg_we_i` to be plain single-cycle levels that are sampled at the clock. They take the address to be stable only in the cycle it is strobed. They assume reset is held for at least one edge before traffic starts. The stimulus changes inputs only on falling edges. It deasserts the strobe between most requests but also issues back-to-back requests. One case sets a control write and a request in the same cycle, which probes the ordering in R11.

// File: rtl/bios_dec_pkg.sv
// Package: shared types and constants for the firmware region decoder.
// Assumes a 32-bit address space split into 64 KB pages for decoding.
package bios_dec_pkg;

    localparam int ADDR_W  = 32;
    localparam int PAGE_LSB = 16;
    localparam int PAGE_W  = ADDR_W - PAGE_LSB;

    // Page numbers (address bits 31:16) of each range
    localparam logic [PAGE_W-1:0] PG_LEG_LO   = 16'h000E;
    localparam logic [PAGE_W-1:0] PG_LEG_HI   = 16'h000F;
    localparam logic [PAGE_W-1:0] PG_TOP_LO   = 16'hFFFE;
    localparam logic [PAGE_W-1:0] PG_TOP_HI   = 16'hFFFF;
    localparam logic [PAGE_W-1:0] PG_EXT_FIRST = 16'hFFF8;
    localparam logic [PAGE_W-1:0] PG_EXT_LAST  = 16'hFFFD;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_LEG_LO,
        RGN_LEG_HI,
        RGN_TOP_LO,
        RGN_TOP_HI,
        RGN_EXT
    } bios_rgn_e;

    typedef struct packed {
        logic claim;
        logic to_mem;
        logic cs;
        logic wp_err;
    } bios_dec_t;

endpackage

// File: rtl/bios_ctrl_reg.sv
// Module: control register holding the region enables and write protect.
// Assumes a write-only port; only the three policy bits are stored.
module bios_ctrl_reg #(
    parameter int CTRL_W     = 8,
    parameter int WP_BIT     = 0,
    parameter int LO_EN_BIT  = 6,
    parameter int EXT_EN_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic              wp_o,
    output logic              lo_en_o,
    output logic              ext_en_o
);
    localparam int NBITS = 3;
    localparam int SEL [NBITS] = '{WP_BIT, LO_EN_BIT, EXT_EN_BIT};

    logic [NBITS-1:0] bits_q;

    // Store each selected policy bit on a write; clear on reset
    for (genvar g = 0; g < NBITS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)     bits_q[g] <= 1'b0;
            else if (we_i)  bits_q[g] <= wdata_i[SEL[g]];
        end
    end

    logic wdata_unused;
    assign wdata_unused = ^wdata_i;

    assign wp_o     = bits_q[0];
    assign lo_en_o  = bits_q[1];
    assign ext_en_o = bits_q[2];
endmodule

// File: rtl/bios_range_classify.sv
// Module: maps the upper address bits onto one firmware range.
// Assumes all ranges are whole 64 KB pages; purely combinational.
module bios_range_classify
    import bios_dec_pkg::*;
(
    input  logic [PAGE_W-1:0] page_i,
    output bios_rgn_e         rgn_o
);
    // Compare the page number against each range
    always_comb begin
        if (page_i == PG_LEG_LO)       rgn_o = RGN_LEG_LO;
        else if (page_i == PG_LEG_HI)  rgn_o = RGN_LEG_HI;
        else if (page_i == PG_TOP_LO)  rgn_o = RGN_TOP_LO;
        else if (page_i == PG_TOP_HI)  rgn_o = RGN_TOP_HI;
        else if (page_i >= PG_EXT_FIRST && page_i <= PG_EXT_LAST)
                                       rgn_o = RGN_EXT;
        else                           rgn_o = RGN_NONE;
    end
endmodule

// File: rtl/bios_route_policy.sv
// Module: turns range, initiator, direction and policy bits into a decision.
// Assumes the range is already classified; purely combinational.
module bios_route_policy
    import bios_dec_pkg::*;
(
    input  bios_rgn_e rgn_i,
    input  logic      from_exp_i,
    input  logic      wr_i,
    input  logic      wp_i,
    input  logic      lo_en_i,
    input  logic      ext_en_i,
    output bios_dec_t dec_o
);
    logic claim, cs_raw, mem;

    // Routing rules per initiator and range
    always_comb begin
        claim  = 1'b0;
        cs_raw = 1'b0;
        mem    = 1'b0;
        if (from_exp_i) begin
            unique case (rgn_i)
                RGN_LEG_HI: begin claim = 1'b1; cs_raw = 1'b1; end
                RGN_LEG_LO: begin
                    claim  = lo_en_i;
                    cs_raw = lo_en_i;
                    mem    = !lo_en_i;
                end
                default: ;
            endcase
        end else begin
            unique case (rgn_i)
                RGN_LEG_HI, RGN_TOP_HI: begin claim = 1'b1; cs_raw = 1'b1; end
                RGN_LEG_LO: begin claim = 1'b1; cs_raw = lo_en_i; end
                RGN_TOP_LO: begin claim = lo_en_i; cs_raw = lo_en_i; end
                RGN_EXT:    begin claim = ext_en_i; cs_raw = ext_en_i; end
                default: ;
            endcase
        end
    end

    // Write protect: keep the claim, drop the select, flag the violation
    always_comb begin
        dec_o.claim  = claim;
        dec_o.to_mem = mem;
        dec_o.wp_err = claim && wr_i && wp_i;
        dec_o.cs     = cs_raw && !(wr_i && wp_i);
    end
endmodule

// File: rtl/bios_region_decoder.sv
// Module: top of the firmware region decoder; registers one decision per request.
// Assumes requests are single-cycle strobes; outputs follow one clock later.
module bios_region_decoder
    import bios_dec_pkg::*;
#(
    parameter int CTRL_W     = 8,
    parameter int WP_BIT     = 0,
    parameter int LO_EN_BIT  = 6,
    parameter int EXT_EN_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [31:0]       addr_i,
    input  logic              wr_i,
    input  logic              from_exp_i,
    input  logic              cfg_we_i,
    input  logic [CTRL_W-1:0] cfg_wdata_i,
    output logic              dec_valid_o,
    output logic              claim_o,
    output logic              to_mem_o,
    output logic              bios_cs_o,
    output logic              wp_err_o
);
    logic      wp_en, lo_en, ext_en;
    bios_rgn_e rgn;
    bios_dec_t dec_d, dec_q;
    logic      valid_q;
    logic      addr_unused;

    assign addr_unused = ^addr_i[PAGE_LSB-1:0];

    bios_ctrl_reg #(
        .CTRL_W(CTRL_W), .WP_BIT(WP_BIT),
        .LO_EN_BIT(LO_EN_BIT), .EXT_EN_BIT(EXT_EN_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
        .wp_o(wp_en), .lo_en_o(lo_en), .ext_en_o(ext_en)
    );

    bios_range_classify u_cls (
        .page_i(addr_i[ADDR_W-1:PAGE_LSB]), .rgn_o(rgn)
    );

    bios_route_policy u_pol (
        .rgn_i(rgn), .from_exp_i(from_exp_i), .wr_i(wr_i), .wp_i(wp_en),
        .lo_en_i(lo_en), .ext_en_i(ext_en), .dec_o(dec_d)
    );

    // Register the decision; idle cycles yield an all-zero result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            dec_q   <= req_i ? dec_d : '0;
            valid_q <= req_i;
        end
    end

    assign dec_valid_o = valid_q;
    assign claim_o     = dec_q.claim;
    assign to_mem_o    = dec_q.to_mem;
    assign bios_cs_o   = dec_q.cs;
    assign wp_err_o    = dec_q.wp_err;
endmodule

// File: rtl/bios_region_decoder_chk.sv
// Module: checker with the temporal properties of the decoder, bound to the top.
// Assumes it sees the top's ports plus its stored write-protect bit.
module bios_region_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic [31:0] addr_i,
    input logic        wr_i,
    input logic        from_exp_i,
    input logic        wp_en,
    input logic        dec_valid_o,
    input logic        claim_o,
    input logic        to_mem_o,
    input logic        bios_cs_o,
    input logic        wp_err_o
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> dec_valid_o) else $error("valid missing");  // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !(dec_valid_o || claim_o || to_mem_o || bios_cs_o || wp_err_o))
        else $error("idle output");  // R2
    AST_CS_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        bios_cs_o |-> claim_o) else $error("cs without claim");  // R3
    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        to_mem_o |-> !(claim_o || bios_cs_o)) else $error("mem overlaps claim");  // R8
    AST_UPPER_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !from_exp_i && !wr_i &&
         (addr_i[31:16] == 16'h000F || addr_i[31:16] == 16'hFFFF))
        |=> (claim_o && bios_cs_o)) else $error("upper half not selected");  // R3
    AST_EXP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && from_exp_i && addr_i[31:16] == 16'h000F)
        |=> (claim_o && !to_mem_o)) else $error("expansion upper lost");  // R7
    AST_WP_BLOCKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        wp_err_o |-> (claim_o && !bios_cs_o)) else $error("protect violation");  // R9
    AST_WP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && wr_i && wp_en && !from_exp_i && addr_i[31:16] == 16'h000F)
        |=> wp_err_o) else $error("protect pulse missing");  // R9
    AST_NONBIOS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && addr_i[31:16] == 16'h1234) |=> !(claim_o || to_mem_o || bios_cs_o))
        else $error("stray claim");  // R10
endmodule

bind bios_region_decoder bios_region_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .wr_i(wr_i),
    .from_exp_i(from_exp_i), .wp_en(wp_en), .dec_valid_o(dec_valid_o),
    .claim_o(claim_o), .to_mem_o(to_mem_o), .bios_cs_o(bios_cs_o),
    .wp_err_o(wp_err_o)
);

// File: tb/test_bios_region_decoder.sv
// Bench: scoreboard. The driver queues expected decisions, the monitor compares them.
module test_bios_region_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic        wr_i = 1'b0;
    logic        from_exp_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [7:0]  cfg_wdata_i = '0;
    logic        dec_valid_o, claim_o, to_mem_o, bios_cs_o, wp_err_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] expq [$];
    string      tagq [$];
    logic [7:0] ctrl_m = '0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    bios_region_decoder i_bios_region_decoder (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .wr_i(wr_i),
        .from_exp_i(from_exp_i), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .dec_valid_o(dec_valid_o), .claim_o(claim_o), .to_mem_o(to_mem_o),
        .bios_cs_o(bios_cs_o), .wp_err_o(wp_err_o)
    );

    // Expected {claim, to_mem, cs, wp_err} derived from the requirements
    function automatic logic [3:0] model(input logic [31:0] a, input logic w,
                                         input logic ex, input logic [7:0] c);
        logic cl, mm, cs;
        logic [15:0] pg;
        pg = a[31:16];
        cl = 0; mm = 0; cs = 0;
        if (ex) begin
            if (pg == 16'h000F) begin cl = 1; cs = 1; end
            else if (pg == 16'h000E) begin
                if (c[6]) begin cl = 1; cs = 1; end else mm = 1;
            end
        end else begin
            if (pg == 16'h000F || pg == 16'hFFFF) begin cl = 1; cs = 1; end
            else if (pg == 16'h000E) begin cl = 1; cs = c[6]; end
            else if (pg == 16'hFFFE) begin cl = c[6]; cs = c[6]; end
            else if (pg >= 16'hFFF8 && pg <= 16'hFFFD) begin cl = c[7]; cs = c[7]; end
        end
        if (cl && w && c[0]) return {cl, mm, 1'b0, 1'b1};
        return {cl, mm, cs, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Driver: one request strobe, expected result queued
    task automatic apply(input string tag, input logic [31:0] a, input logic w,
                         input logic ex, input bit hold = 1'b0);
        @(negedge clk);
        req_i = 1; addr_i = a; wr_i = w; from_exp_i = ex;
        expq.push_back(model(a, w, ex, ctrl_m));
        tagq.push_back(tag);
        if (!hold) begin @(negedge clk); req_i = 0; end
    endtask

    task automatic cfg(input logic [7:0] d);
        @(negedge clk);
        req_i = 0; cfg_we_i = 1; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 0;
        ctrl_m = d;
    endtask

    // Monitor: compares each valid decision with the queue head; idle must be silent
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (dec_valid_o) begin
                if (expq.size() == 0) check("R2 unexpected valid", 4'b1111, 4'b0000);
                else check(tagq.pop_front(), {claim_o, to_mem_o, bios_cs_o, wp_err_o},
                           expq.pop_front());
            end else if (expq.size() != 0 && !req_i) begin
                check("R2 valid missing", {dec_valid_o, 3'b000}, 4'b1000);
                void'(expq.pop_front()); void'(tagq.pop_front());
            end else if (claim_o | to_mem_o | bios_cs_o | wp_err_o)
                check("R2 idle outputs", {claim_o, to_mem_o, bios_cs_o, wp_err_o}, 4'b0000);
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", {dec_valid_o, claim_o, to_mem_o, bios_cs_o},
              4'b0000);
        @(negedge clk); rst_n = 1;
        // R1: register reset shows as lower half without select
        apply("R1 reset ctrl lower", 32'h000E_1000, 0, 0);
        apply("R3 host upper legacy", 32'h000F_FFF0, 0, 0);
        apply("R3 host upper alias", 32'hFFFF_FFF0, 0, 0);
        apply("R5 top lower disabled", 32'hFFFE_0000, 0, 0);
        apply("R6 ext disabled", 32'hFFF8_0000, 0, 0);
        apply("R8 exp lower to mem", 32'h000E_8000, 0, 1);
        apply("R7 exp upper", 32'h000F_0000, 0, 1);
        apply("R8 exp high ignored", 32'hFFFF_0000, 0, 1);
        apply("R10 outside", 32'h1234_0000, 0, 0);
        apply("R10 below window", 32'h000D_FFFF, 0, 0);
        apply("R6 above ext", 32'hFFF7_FFFF, 0, 0);
        cfg(8'hC0);
        apply("R4 host lower enabled", 32'h000E_FFFF, 0, 0);
        apply("R5 top lower enabled", 32'hFFFE_FFFF, 1, 0);
        apply("R6 ext first", 32'hFFF8_0000, 0, 0);
        apply("R6 ext last", 32'hFFFD_FFFF, 1, 0);
        apply("R8 exp lower enabled", 32'h000E_0000, 1, 1);
        // back-to-back requests
        apply("R2 back to back a", 32'h000F_1234, 0, 0, 1);
        apply("R2 back to back b", 32'h1000_0000, 0, 0, 1);
        apply("R2 back to back c", 32'hFFFA_0000, 0, 0);
        cfg(8'hC1);
        apply("R9 write upper protected", 32'h000F_0000, 1, 0);
        apply("R9 read upper protected", 32'h000F_0000, 0, 0);
        apply("R9 write ext protected", 32'hFFFC_0000, 1, 0);
        apply("R9 exp write lower protected", 32'h000E_0000, 1, 1);
        apply("R9 write outside", 32'h2000_0000, 1, 0);
        cfg(8'h01);
        apply("R9 exp write to mem not flagged", 32'h000E_0004, 1, 1);
        apply("R9 write lower claimed no cs", 32'h000E_0004, 1, 0);
        // R11: write and request in the same cycle use the old value
        @(negedge clk);
        cfg_we_i = 1; cfg_wdata_i = 8'h40;
        req_i = 1; addr_i = 32'hFFFE_0010; wr_i = 0; from_exp_i = 0;
        expq.push_back(model(32'hFFFE_0010, 0, 0, ctrl_m)); tagq.push_back("R11 same cycle old");
        @(negedge clk);
        cfg_we_i = 0; req_i = 0; ctrl_m = 8'h40;
        apply("R11 next cycle new", 32'hFFFE_0010, 0, 0);
        repeat (4) @(negedge clk);
        if (expq.size() != 0) check("R2 pending results", 4'(expq.size()), 4'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule